// File: doc/BRIEF.md
# Attribute-Steered Direct-Mapped Data Cache

This block sits between a processor load/store port and a slower memory bus that moves one 32-bit word per beat. Each access arrives with its own attributes: a device flag, a shareable flag, a two-bit allocation mode and a write-mode bit that selects write-back or write-through. From these attributes the block decides, for each access, whether to look in the cache, whether a miss fetches a line, and whether a store is sent to memory or only marks the line dirty. Lines are eight words long. The cache is direct-mapped and holds `LINES` lines. Addresses are word addresses: bits [2:0] select the word, the next log2(LINES) bits select the index and the remaining bits form the tag.

Both data interfaces use valid/ready. On the processor side the requester raises `cpu_valid` and holds the command, address and write data stable until it sees `cpu_ready` high at a clock edge. `cpu_ready` is high for one cycle only, and `cpu_rdata` is valid in that cycle. On the memory side the block raises `mem_valid` and holds address, direction and write data stable until `mem_ready` is sampled high. For a read beat, `mem_rdata` must be valid in the cycle in which `mem_ready` is high. Memory may hold `mem_ready` low for any number of cycles, and the block waits.

A one-cycle `clean_req` pulse names a line index. The block remembers one pending request, and a later pulse replaces it. When the block is idle it serves the pending clean before any processor access, then pulses `clean_done`.

Top module: `dc_cache`

## Requirements
- R1: A cacheable read that hits completes in the cycle it is presented (`cpu_ready` high with no memory beat), returning the cached word.
- R2: A cacheable read miss with allocation mode 01 (read) or 10 (read/write) fills the line with eight read beats in ascending word order, starting at the aligned base, then returns the requested word.
- R3: With allocation mode 00 (none) or 11 (treated as none), a miss makes a single memory beat, and the line stays unallocated, so a repeat access goes to memory again.
- R4: With allocation mode 01, a write miss makes one memory write and no linefill.
- R5: With allocation mode 10, a write miss fills the line first and then merges the store, which is then handled by its write mode.
- R6: A write-through store (write-mode bit 0) that hits updates the cached word and makes exactly one memory write.
- R7: A write-back store (write-mode bit 1) that hits updates only the cached word and marks the line dirty, with no memory beat.
- R8: A linefill that replaces a dirty line first writes the old line back with eight write beats in ascending order at the old tag's address.
- R9: A device access always makes a single memory beat and never reads, fills or updates the cache, even when the address is cached.
- R10: A shareable access bypasses the cache like a device access unless `share_cache_en` is 1, in which case it is cached normally.
- R11: A clean of a dirty line writes it back with eight ascending write beats and clears its dirty bit, while the line stays valid. A clean of a clean line makes no beat. Every clean ends with a one-cycle `clean_done` pulse.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold their values.
- R13: Reset invalidates every line, and leaves `cpu_ready`, `mem_valid` and `clean_done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_device | input | 1 | Device-type access |
| cpu_share | input | 1 | Shareable access |
| cpu_alloc | input | 2 | 00 none, 01 read, 10 read/write, 11 none |
| cpu_wback | input | 1 | 1 = write-back, 0 = write-through |
| share_cache_en | input | 1 | Allow caching of shareable accesses |
| clean_req | input | 1 | One-cycle clean request pulse |
| clean_idx | input | log2(LINES) | Line index to clean |
| clean_done | output | 1 | One-cycle pulse when the clean ends |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 = write beat |
| mem_addr | output | AW | Word address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with mem_ready |

## Verification
The assertions check four things on every cycle: the memory request holds still under back-pressure, read hits and write-back store hits complete with no memory beat, device accesses never allocate a line, and `clean_done` never stays high for more than one cycle. Other behaviour only the bench's scenarios can show. That covers the ascending order of fill and write-back beats, write-back before refill on a dirty eviction, and the store merged after a write-allocate fill. It also covers the line staying valid after a clean, and the shareable and no-allocate paths leaving the cache untouched. The bench shows these by observing the beat log, the memory contents and the data returned by later reads.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int WORD_W   = 32;
  localparam int LINE_WDS = 8;
  localparam int OFF_W    = $clog2(LINE_WDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SINGLE, ST_WB, ST_FILL, ST_CDONE
  } dc_state_e;

  typedef enum logic [1:0] {
    ALC_NONE = 2'b00,
    ALC_RD   = 2'b01,
    ALC_RDWR = 2'b10,
    ALC_RSVD = 2'b11
  } dc_alloc_e;
endpackage

// File: rtl/dc_policy.sv
module dc_policy (
  input  logic       is_write,
  input  logic       device,
  input  logic       share,
  input  logic       share_en,
  input  logic [1:0] alloc,
  output logic       cacheable,
  output logic       alloc_miss
);
  import dc_pkg::*;

  always_comb begin
    cacheable  = !device && (!share || share_en);
    alloc_miss = cacheable &&
                 ((alloc == ALC_RDWR) || ((alloc == ALC_RD) && !is_write));
  end
endmodule

// File: rtl/dc_store.sv
module dc_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = dc_pkg::OFF_W,
  localparam int DW    = dc_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [OFF_W-1:0] a_off,
  output logic             a_valid,
  output logic             a_dirty,
  output logic [TAG_W-1:0] a_tag,
  output logic [DW-1:0]    a_word,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [OFF_W-1:0] b_off,
  output logic             b_valid,
  output logic             b_dirty,
  output logic [TAG_W-1:0] b_tag,
  output logic [DW-1:0]    b_word,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data,
  input  logic             dirty_set,
  input  logic             meta_en,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [TAG_W-1:0] meta_tag,
  input  logic             clr_en
);
  logic [DW-1:0]    data_q  [LINES][dc_pkg::LINE_WDS];
  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx][wr_off] <= wr_data;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else begin
        if (meta_en && op_idx == IDX_W'(g)) begin
          valid_q[g] <= 1'b1;
          tag_q[g]   <= meta_tag;
          dirty_q[g] <= 1'b0;
        end
        if (clr_en && op_idx == IDX_W'(g)) dirty_q[g] <= 1'b0;
        if (wr_en && dirty_set && wr_idx == IDX_W'(g)) dirty_q[g] <= 1'b1;
      end
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_dirty = dirty_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_word  = data_q[a_idx][a_off];
  assign b_valid = valid_q[b_idx];
  assign b_dirty = dirty_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_word  = data_q[b_idx][b_off];
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl #(
  parameter int AW    = 10,
  parameter int IDX_W = 3,
  parameter int TAG_W = 4,
  localparam int OFF_W = dc_pkg::OFF_W,
  localparam int DW    = dc_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_wback,
  input  logic             cacheable,
  input  logic             alloc_miss,
  output logic             cpu_ready,
  output logic [DW-1:0]    cpu_rdata,
  output logic             lk_hit,
  input  logic             lk_valid,
  input  logic             lk_dirty,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [DW-1:0]    lk_word,
  output logic [IDX_W-1:0] b_idx,
  output logic [OFF_W-1:0] b_off,
  input  logic             b_valid,
  input  logic             b_dirty,
  input  logic [TAG_W-1:0] b_tag,
  input  logic [DW-1:0]    b_word,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [OFF_W-1:0] wr_off,
  output logic [DW-1:0]    wr_data,
  output logic             dirty_set,
  output logic             meta_en,
  output logic [TAG_W-1:0] meta_tag,
  output logic             clr_en,
  output logic [IDX_W-1:0] op_idx,
  input  logic             clean_req,
  input  logic [IDX_W-1:0] clean_idx,
  output logic             clean_done,
  output logic             mem_valid,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata
);
  import dc_pkg::*;

  dc_state_e        state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] op_idx_q, op_idx_d;
  logic [TAG_W-1:0] op_tag_q, op_tag_d;
  logic             ret_fill_q, ret_fill_d;
  logic             cpend_q, cpend_take;
  logic [IDX_W-1:0] cidx_q;

  logic [OFF_W-1:0] cpu_off;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  logic             last_beat;

  assign cpu_off   = cpu_addr[OFF_W-1:0];
  assign cpu_idx   = cpu_addr[IDX_W+OFF_W-1:OFF_W];
  assign cpu_tag   = cpu_addr[AW-1:IDX_W+OFF_W];
  assign lk_hit    = lk_valid && (lk_tag == cpu_tag);
  assign last_beat = (cnt_q == OFF_W'(LINE_WDS - 1));
  assign op_idx    = op_idx_q;
  assign b_idx     = (state_q == ST_IDLE) ? cidx_q : op_idx_q;
  assign b_off     = cnt_q;
  assign meta_tag  = op_tag_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    op_idx_d   = op_idx_q;
    op_tag_d   = op_tag_q;
    ret_fill_d = ret_fill_q;
    cpend_take = 1'b0;
    cpu_ready  = 1'b0;
    cpu_rdata  = lk_word;
    wr_en      = 1'b0;
    wr_idx     = cpu_idx;
    wr_off     = cpu_off;
    wr_data    = cpu_wdata;
    dirty_set  = 1'b0;
    meta_en    = 1'b0;
    clr_en     = 1'b0;
    clean_done = 1'b0;
    mem_valid  = 1'b0;
    mem_write  = 1'b0;
    mem_addr   = cpu_addr;
    mem_wdata  = cpu_wdata;

    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (cpend_q) begin
          cpend_take = 1'b1;
          op_idx_d   = cidx_q;
          ret_fill_d = 1'b0;
          state_d    = (b_valid && b_dirty) ? ST_WB : ST_CDONE;
        end else if (cpu_valid) begin
          if (cacheable && lk_hit) begin
            if (!cpu_write) begin
              cpu_ready = 1'b1;
            end else if (cpu_wback) begin
              cpu_ready = 1'b1;
              wr_en     = 1'b1;
              dirty_set = 1'b1;
            end else begin
              state_d = ST_SINGLE;
            end
          end else if (alloc_miss) begin
            op_idx_d   = cpu_idx;
            op_tag_d   = cpu_tag;
            ret_fill_d = 1'b1;
            state_d    = (lk_valid && lk_dirty) ? ST_WB : ST_FILL;
          end else begin
            state_d = ST_SINGLE;
          end
        end
      end
      ST_SINGLE: begin
        mem_valid = 1'b1;
        mem_write = cpu_write;
        if (mem_ready) begin
          cpu_ready = 1'b1;
          cpu_rdata = mem_rdata;
          wr_en     = cpu_write && cacheable && lk_hit;
          state_d   = ST_IDLE;
        end
      end
      ST_WB: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {b_tag, op_idx_q, cnt_q};
        mem_wdata = b_word;
        if (mem_ready) begin
          cnt_d = cnt_q + 1'b1;
          if (last_beat) begin
            clr_en  = 1'b1;
            state_d = ret_fill_q ? ST_FILL : ST_CDONE;
          end
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {op_tag_q, op_idx_q, cnt_q};
        wr_idx    = op_idx_q;
        wr_off    = cnt_q;
        wr_data   = mem_rdata;
        if (mem_ready) begin
          wr_en = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (last_beat) begin
            meta_en = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_CDONE: begin
        clean_done = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      op_idx_q   <= '0;
      op_tag_q   <= '0;
      ret_fill_q <= 1'b0;
      cpend_q    <= 1'b0;
      cidx_q     <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      op_idx_q   <= op_idx_d;
      op_tag_q   <= op_tag_d;
      ret_fill_q <= ret_fill_d;
      if (clean_req) begin
        cpend_q <= 1'b1;
        cidx_q  <= clean_idx;
      end else if (cpend_take) begin
        cpend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dc_cache.sv
module dc_cache #(
  parameter int AW    = 10,
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = dc_pkg::OFF_W,
  localparam int TAG_W = AW - IDX_W - OFF_W,
  localparam int DW    = dc_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  output logic             cpu_ready,
  input  logic             cpu_write,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             cpu_device,
  input  logic             cpu_share,
  input  logic [1:0]       cpu_alloc,
  input  logic             cpu_wback,
  input  logic             share_cache_en,
  input  logic             clean_req,
  input  logic [IDX_W-1:0] clean_idx,
  output logic             clean_done,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  logic             cacheable, alloc_miss, lk_hit;
  logic             lk_valid, lk_dirty, b_valid, b_dirty;
  logic [TAG_W-1:0] lk_tag, b_tag, meta_tag;
  logic [DW-1:0]    lk_word, b_word, wr_data;
  logic [IDX_W-1:0] b_idx, wr_idx, op_idx;
  logic [OFF_W-1:0] b_off, wr_off;
  logic             wr_en, dirty_set, meta_en, clr_en;

  dc_policy u_policy (
    .is_write(cpu_write), .device(cpu_device), .share(cpu_share),
    .share_en(share_cache_en), .alloc(cpu_alloc),
    .cacheable(cacheable), .alloc_miss(alloc_miss)
  );

  dc_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_addr[IDX_W+OFF_W-1:OFF_W]), .a_off(cpu_addr[OFF_W-1:0]),
    .a_valid(lk_valid), .a_dirty(lk_dirty), .a_tag(lk_tag), .a_word(lk_word),
    .b_idx(b_idx), .b_off(b_off),
    .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag), .b_word(b_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .dirty_set(dirty_set), .meta_en(meta_en), .op_idx(op_idx),
    .meta_tag(meta_tag), .clr_en(clr_en)
  );

  dc_ctrl #(.AW(AW), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wback(cpu_wback),
    .cacheable(cacheable), .alloc_miss(alloc_miss),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .lk_hit(lk_hit),
    .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag), .lk_word(lk_word),
    .b_idx(b_idx), .b_off(b_off),
    .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag), .b_word(b_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .dirty_set(dirty_set), .meta_en(meta_en), .meta_tag(meta_tag),
    .clr_en(clr_en), .op_idx(op_idx),
    .clean_req(clean_req), .clean_idx(clean_idx), .clean_done(clean_done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/dc_cache_chk.sv
module dc_cache_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          cpu_write,
  input logic          cpu_wback,
  input logic          cpu_valid,
  input logic          cpu_device,
  input logic          cacheable,
  input logic          lk_hit,
  input logic          meta_en,
  input logic          clean_done,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata
);
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_wdata));

  p_read_hit_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cpu_write && cacheable && lk_hit |-> !mem_valid);

  p_wb_hit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_write && cpu_wback && cacheable && lk_hit |-> !mem_valid);

  p_device_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_device |-> !meta_en);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clean_done |=> !clean_done);
endmodule

bind dc_cache dc_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
  .cpu_wback(cpu_wback), .cpu_valid(cpu_valid), .cpu_device(cpu_device),
  .cacheable(cacheable), .lk_hit(lk_hit), .meta_en(meta_en),
  .clean_done(clean_done), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/dc_cache_tb.sv
module dc_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LINES = 8;
  localparam int MEMW = 1 << AW;

  typedef struct packed {
    logic        wr;
    logic [1:0]  alc;
    logic        wb;
    logic        dev;
    logic        shr;
    logic [11:0] adr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [4:0]  nrd;
    logic [4:0]  nwr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 12'h010, 32'h0,        32'h5A000010, 5'd8, 5'd0, 4'd2},  // R2
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 12'h013, 32'h0,        32'h5A000013, 5'd0, 5'd0, 4'd1},  // R1
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 12'h013, 32'hDEAD0013, 32'h0,        5'd0, 5'd1, 4'd6},  // R6
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 12'h013, 32'h0,        32'hDEAD0013, 5'd0, 5'd0, 4'd6},  // R6
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 12'h020, 32'h0,        32'h5A000020, 5'd1, 5'd0, 4'd3},  // R3
    '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 12'h020, 32'h0,        32'h5A000020, 5'd1, 5'd0, 4'd3},  // R3
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 12'h028, 32'h11110028, 32'h0,        5'd0, 5'd1, 4'd4},  // R4
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 12'h028, 32'h0,        32'h11110028, 5'd1, 5'd0, 4'd4},  // R4
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 12'h031, 32'h22220031, 32'h0,        5'd8, 5'd0, 4'd5},  // R5
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 12'h031, 32'h0,        32'h22220031, 5'd0, 5'd0, 4'd5},  // R5
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 12'h032, 32'h33330032, 32'h0,        5'd0, 5'd0, 4'd7},  // R7
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 12'h072, 32'h0,        32'h5A000072, 5'd8, 5'd8, 4'd8},  // R8
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 12'h032, 32'h0,        32'h33330032, 5'd1, 5'd0, 4'd8},  // R8
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 12'h072, 32'h0,        32'h5A000072, 5'd1, 5'd0, 4'd9},  // R9
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 12'h072, 32'h44440072, 32'h0,        5'd0, 5'd1, 4'd9},  // R9
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 12'h072, 32'h0,        32'h5A000072, 5'd0, 5'd0, 4'd9},  // R9
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 12'h0A0, 32'h0,        32'h5A0000A0, 5'd1, 5'd0, 4'd10}, // R10
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 12'h0A0, 32'h0,        32'h5A0000A0, 5'd1, 5'd0, 4'd10}  // R10
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_device = 1'b0, cpu_share = 1'b0;
  logic cpu_wback = 1'b0, share_cache_en = 1'b0, clean_req = 1'b0;
  logic [1:0] cpu_alloc = 2'd0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [2:0] clean_idx = '0;
  logic cpu_ready, clean_done, mem_valid, mem_write;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, cpu_rdata, mem_rdata;

  logic [31:0] mem_arr [MEMW];
  logic [AW-1:0] log_a [64];
  logic log_w [64];
  int nlog = 0, nrd = 0, nwr = 0;
  int checks = 0, errors = 0, hold_err = 0, cyc = 0;
  logic p_pend = 1'b0, p_w = 1'b0;
  logic [AW-1:0] p_a = '0;
  logic [31:0] p_d = '0;

  dc_cache #(.AW(AW), .LINES(LINES)) u_dut (.*);

  assign mem_rdata = mem_arr[mem_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < MEMW; i++) mem_arr[i] = 32'h5A000000 ^ 32'(i);

  // memory model: ready toggles every cycle, beats logged away from the edge
  always @(negedge clk) begin
    mem_ready = ~mem_ready;
    if (p_pend && !(mem_valid && mem_addr == p_a && mem_write == p_w && mem_wdata == p_d))
      hold_err++;
    p_pend = mem_valid && !mem_ready;
    p_a = mem_addr; p_w = mem_write; p_d = mem_wdata;
    if (mem_valid && mem_ready) begin
      if (nlog < 64) begin log_a[nlog] = mem_addr; log_w[nlog] = mem_write; end
      nlog++;
      if (mem_write) begin nwr++; mem_arr[mem_addr] = mem_wdata; end
      else nrd++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    nlog = 0; nrd = 0; nwr = 0;
  endtask

  task automatic cpu_op(input logic wr, input logic [1:0] alc, input logic wb,
                        input logic dev, input logic shr, input logic [AW-1:0] adr,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
    clr_log();
    @(negedge clk);
    cpu_write = wr; cpu_alloc = alc; cpu_wback = wb; cpu_device = dev;
    cpu_share = shr; cpu_addr = adr; cpu_wdata = wd; cpu_valid = 1'b1;
    waits = 0;
    #1;
    while (!cpu_ready && waits < 2000) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic do_clean(input logic [2:0] idx, output int waits);
    clr_log();
    @(negedge clk);
    clean_req = 1'b1; clean_idx = idx;
    @(negedge clk);
    clean_req = 1'b0;
    waits = 0;
    #1;
    while (!clean_done && waits < 2000) begin
      @(negedge clk); #1; waits++;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    int w;
    repeat (3) @(negedge clk);
    #1;
    // R13: reset state
    chk(!cpu_ready && !mem_valid && !clean_done, "R13", "outputs low in reset",
        {29'd0, cpu_ready, mem_valid, clean_done}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cpu_op(VEC[v].wr, VEC[v].alc, VEC[v].wb, VEC[v].dev, VEC[v].shr,
             AW'(VEC[v].adr), VEC[v].wd, rd, w);
      if (!VEC[v].wr)
        chk(rd == VEC[v].rd, $sformatf("R%0d", VEC[v].req), $sformatf("vec %0d rdata", v),
            rd, VEC[v].rd);
      chk(nrd == int'(VEC[v].nrd), $sformatf("R%0d", VEC[v].req), $sformatf("vec %0d read beats", v),
          32'(nrd), 32'(VEC[v].nrd));
      chk(nwr == int'(VEC[v].nwr), $sformatf("R%0d", VEC[v].req), $sformatf("vec %0d write beats", v),
          32'(nwr), 32'(VEC[v].nwr));
      if (v == 0) chk(w > 0, "R13", "first read after reset misses", 32'(w), 32'd1);
      if (v == 1) chk(w == 0, "R1", "hit completes without wait", 32'(w), 32'd0);
    end

    // R10: shareable cached once enabled
    share_cache_en = 1'b1;
    cpu_op(1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 10'h0A0, 32'h0, rd, w);
    chk(nrd == 8 && rd == 32'h5A0000A0, "R10", "shareable fill when enabled", 32'(nrd), 32'd8);
    cpu_op(1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 10'h0A0, 32'h0, rd, w);
    chk(nlog == 0, "R10", "shareable hit when enabled", 32'(nlog), 32'd0);
    share_cache_en = 1'b0;

    // R11: clean a dirty line
    cpu_op(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 10'h0A5, 32'h555500A5, rd, w);
    chk(nlog == 0, "R7", "write-back hit quiet", 32'(nlog), 32'd0);
    do_clean(3'd4, w);
    chk(w < 2000, "R11", "clean_done seen", 32'(w), 32'd0);
    chk(nwr == 8 && nrd == 0, "R11", "clean write beats", 32'(nwr), 32'd8);
    for (int i = 0; i < 8; i++)
      chk(log_w[i] && log_a[i] == AW'(10'h0A0 + i), "R11", "clean beat address",
          32'(log_a[i]), 32'(10'h0A0 + i));
    cpu_op(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 10'h0A5, 32'h0, rd, w);
    chk(rd == 32'h555500A5, "R11", "memory holds cleaned data", rd, 32'h555500A5);
    cpu_op(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 10'h0A5, 32'h0, rd, w);
    chk(nlog == 0 && rd == 32'h555500A5, "R11", "line valid after clean", 32'(nlog), 32'd0);
    do_clean(3'd4, w);
    chk(w < 2000 && nlog == 0, "R11", "clean of clean line no beats", 32'(nlog), 32'd0);

    // R8 / R2: eviction order then fill order
    cpu_op(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 10'h0A6, 32'h666600A6, rd, w);
    cpu_op(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 10'h025, 32'h0, rd, w);
    chk(rd == 32'h5A000025 && nlog == 16, "R8", "evict+fill beats", 32'(nlog), 32'd16);
    for (int i = 0; i < 8; i++) begin
      chk(log_w[i] && log_a[i] == AW'(10'h0A0 + i), "R8", "write-back beat order",
          32'(log_a[i]), 32'(10'h0A0 + i));
      chk(!log_w[8+i] && log_a[8+i] == AW'(10'h020 + i), "R2", "fill beat order",
          32'(log_a[8+i]), 32'(10'h020 + i));
    end
    chk(mem_arr[10'h0A6] == 32'h666600A6, "R8", "evicted data in memory",
        mem_arr[10'h0A6], 32'h666600A6);

    // R12: request held under back-pressure
    chk(hold_err == 0, "R12", "memory request stable while stalled", 32'(hold_err), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule